// File: doc/BRIEF.md
# Z80 Window Page Mapper

This block sits between a Z80-class CPU and a 4 MB physical memory space. It cuts the 64 KB CPU address space into four 16 KB windows. Each window has its own 8-bit page number, and that page number becomes the upper eight bits of a 22-bit physical address. CPU address bits A15:A14 pick the window, and bits A13:A0 pass through unchanged as the offset inside the page. The top three physical bits are decoded into eight active-low 512 KB chip selects. The decode applies only to real memory cycles.

Software loads the four page numbers with I/O writes to four consecutive port addresses. Each write carries one data-bus byte per entry. A separate control port holds the map-enable bit and seven general-purpose output bits. Reset clears that register. The page registers are not initialised at reset, so the translated page is forced to all ones until software sets the enable bit. In that state every window shows the top 16 KB of the 4 MB space, which is where the boot ROM sits. Boot code writes all four entries first and then sets the enable bit. From then on the mapping follows the register contents.

Top module: `z80_page_mapper`

## Requirements
- R1: A synchronous reset clears the control register. After reset the map is disabled and `gp_out` is 0.
- R2: While the map is disabled, `phys_addr[21:14]` is 8'hFF for every CPU address, whatever the page entries hold.
- R3: While the map is enabled, `phys_addr[21:14]` equals the page entry selected by `cpu_addr[15:14]`, with 0, 1, 2 and 3 selecting the windows at 0x0000, 0x4000, 0x8000 and 0xC000.
- R4: An I/O write has `iorq_n`=0, `wr_n`=0 and `cpu_addr[7:0]` = `MAP_PORT_BASE` + k for k in 0..3, where `MAP_PORT_BASE` is 8'h60 and aligned to 4. Such a write stores the whole `cpu_data` byte into entry k at that clock edge. The new value steers translation from the next cycle on.
- R5: The map entries stay unchanged in four cases: `iorq_n` is high, `wr_n` is high, the port address is outside the four map ports, or the cycle is a memory write.
- R6: An I/O write to `CTRL_PORT` (8'h64) loads `cpu_data[0]` as the map enable and `cpu_data[7:1]` onto `gp_out[6:0]`. The new value takes effect from the next cycle.
- R7: `chip_sel_n[i]` is low exactly when `mreq_n`=0, `rfsh_n`=1 and `phys_addr[21:19]`=i. During I/O or refresh cycles all eight selects are high.
- R8: `phys_addr[13:0]` always equals `cpu_addr[13:0]`.
- R9: Clearing the enable bit brings back the all-ones page. The entries are kept, and setting the bit again restores the previous translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, used on port writes |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| phys_addr | output | 22 | Translated physical address |
| chip_sel_n | output | 8 | Active-low 512 KB chip selects |
| gp_out | output | 7 | General-purpose control outputs |

## Verification
The translation path and the chip-select decode are combinational. The bench changes the address and strobes on the falling clock edge and checks `phys_addr` and `chip_sel_n` one time unit later, in the same cycle. Port writes land on the next rising edge. Results that depend on a port write (R3, R4, R6, R9) are therefore checked in the cycle after the write strobe, never in the cycle that carries it. For writes that must have no effect, the bench reads every window back through `phys_addr` with the map enabled, after the write and before the next one.

// File: rtl/z80map_pkg.sv
package z80map_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 8;
    localparam int NUM_WIN  = 4;
    localparam int WIN_BITS = $clog2(NUM_WIN);
    localparam int OFFS_W   = CPU_AW - WIN_BITS;
    localparam int PHYS_AW  = OFFS_W + PAGE_W;
    localparam int NUM_CS   = 8;
    localparam int CS_BITS  = $clog2(NUM_CS);
    localparam int GP_W     = DATA_W - 1;
    localparam int PORT_W   = 8;

    typedef logic [PAGE_W-1:0]   page_t;
    typedef logic [WIN_BITS-1:0] win_t;
    typedef logic [PORT_W-1:0]   port_t;

    typedef struct packed {
        logic [NUM_WIN-1:0] map_we;
        logic               ctrl_we;
    } port_wr_t;

    typedef struct packed {
        logic            map_en;
        logic [GP_W-1:0] gp;
    } ctrl_t;

    localparam page_t BOOT_PAGE = '1;

    function automatic page_t pick_page(input logic en, input page_t mapped);
        return en ? mapped : BOOT_PAGE;
    endfunction

    function automatic logic [NUM_CS-1:0] cs_decode(input logic active,
                                                    input logic [CS_BITS-1:0] sel);
        logic [NUM_CS-1:0] v;
        v = '0;
        if (active) v[sel] = 1'b1;
        return ~v;
    endfunction

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
    import z80map_pkg::*;
#(
    parameter port_t MAP_PORT_BASE = 8'h60,
    parameter port_t CTRL_PORT     = 8'h64
) (
    input  port_t    port_addr,
    input  logic     iorq_n,
    input  logic     wr_n,
    output port_wr_t wr
);
    localparam port_t BLOCK_MASK = ~port_t'(NUM_WIN - 1);

    logic io_wr;
    logic in_block;

    always_comb begin
        io_wr    = !iorq_n && !wr_n;
        in_block = (port_addr & BLOCK_MASK) == (MAP_PORT_BASE & BLOCK_MASK);
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_we
        always_comb wr.map_we[g] = io_wr && in_block &&
                                   (port_addr[WIN_BITS-1:0] == WIN_BITS'(g));
    end

    always_comb wr.ctrl_we = io_wr && (port_addr == CTRL_PORT);

    always_comb begin
        assert ($onehot0({wr.map_we, wr.ctrl_we}))
            else $error("assert_single_target_R4: two port targets at once");
    end

endmodule

// File: rtl/page_map_regs.sv
module page_map_regs
    import z80map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WIN-1:0] we,
    input  page_t              wdata,
    input  win_t               rd_sel,
    output page_t              rd_page
);
    page_t entry_q [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we[g]) entry_q[g] <= wdata;
        end

        assert_entry_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !we[g] |=> $stable(entry_q[g]));

        assert_entry_load_R4: assert property (@(posedge clk) disable iff (rst)
            we[g] |=> (entry_q[g] == $past(wdata)));
    end

    always_comb rd_page = entry_q[rd_sel];

endmodule

// File: rtl/ctrl_latch.sv
module ctrl_latch
    import z80map_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  page_t wdata,
    output ctrl_t ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= '{map_en: wdata[0], gp: wdata[DATA_W-1:1]};
    end

    always_comb ctrl = ctrl_q;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctrl_q));

endmodule

// File: rtl/chip_select_decode.sv
module chip_select_decode
    import z80map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mreq_n,
    input  logic               rfsh_n,
    input  logic [CS_BITS-1:0] bank,
    output logic [NUM_CS-1:0]  cs_n
);
    logic mem_cycle;

    always_comb begin
        mem_cycle = !mreq_n && rfsh_n;
        cs_n      = cs_decode(mem_cycle, bank);
    end

    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_cs_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (mreq_n || !rfsh_n) |-> (&cs_n));

endmodule

// File: rtl/z80_page_mapper.sv
module z80_page_mapper
    import z80map_pkg::*;
#(
    parameter logic [7:0] MAP_PORT_BASE = 8'h60,
    parameter logic [7:0] CTRL_PORT     = 8'h64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        iorq_n,
    input  logic        wr_n,
    input  logic        mreq_n,
    input  logic        rfsh_n,
    output logic [21:0] phys_addr,
    output logic [7:0]  chip_sel_n,
    output logic [6:0]  gp_out
);
    port_wr_t port_wr;
    page_t    mapped_page;
    page_t    eff_page;
    ctrl_t    ctrl;

    io_port_decode #(
        .MAP_PORT_BASE (MAP_PORT_BASE),
        .CTRL_PORT     (CTRL_PORT)
    ) decode_i (
        .port_addr (cpu_addr[PORT_W-1:0]),
        .iorq_n    (iorq_n),
        .wr_n      (wr_n),
        .wr        (port_wr)
    );

    page_map_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (port_wr.map_we),
        .wdata   (cpu_data),
        .rd_sel  (cpu_addr[CPU_AW-1 -: WIN_BITS]),
        .rd_page (mapped_page)
    );

    ctrl_latch ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (port_wr.ctrl_we),
        .wdata (cpu_data),
        .ctrl  (ctrl)
    );

    always_comb begin
        eff_page  = pick_page(ctrl.map_en, mapped_page);
        phys_addr = {eff_page, cpu_addr[OFFS_W-1:0]};
        gp_out    = ctrl.gp;
    end

    chip_select_decode cs_i (
        .clk    (clk),
        .rst    (rst),
        .mreq_n (mreq_n),
        .rfsh_n (rfsh_n),
        .bank   (phys_addr[PHYS_AW-1 -: CS_BITS]),
        .cs_n   (chip_sel_n)
    );

    assert_boot_page_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.map_en |-> (&phys_addr[PHYS_AW-1:OFFS_W]));

    assert_offset_pass_R8: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

endmodule

// File: tb/z80_page_mapper_tb.sv
module z80_page_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        iorq_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        mreq_n = 1'b1;
    logic        rfsh_n = 1'b1;
    logic [21:0] phys_addr;
    logic [7:0]  chip_sel_n;
    logic [6:0]  gp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_map [4];
    logic       m_en;
    logic [6:0] m_gp;

    always #5 clk = ~clk;

    z80_page_mapper dut_i (
        .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .iorq_n (iorq_n), .wr_n (wr_n), .mreq_n (mreq_n), .rfsh_n (rfsh_n),
        .phys_addr (phys_addr), .chip_sel_n (chip_sel_n), .gp_out (gp_out)
    );

    function automatic logic [21:0] exp_phys(input logic [15:0] a);
        logic [7:0] p;
        p = m_en ? m_map[a[15:14]] : 8'hFF;
        return {p, a[13:0]};
    endfunction

    function automatic logic [7:0] exp_cs(input logic [15:0] a, input logic mq, input logic rf);
        logic [21:0] p;
        logic [7:0]  v;
        p = exp_phys(a);
        v = 8'hFF;
        if (!mq && rf) v[p[21:19]] = 1'b0;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Generic bus cycle: drive at negedge, hold over one posedge, release.
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                             input logic io, input logic w, input logic mq);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; iorq_n = io; wr_n = w; mreq_n = mq; rfsh_n = 1'b1;
        @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1; mreq_n = 1'b1;
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] d);
        bus_cycle({8'h00, port}, d, 1'b0, 1'b0, 1'b1);
        if (port >= 8'h60 && port <= 8'h63) m_map[port[1:0]] = d;
        if (port == 8'h64) begin m_en = d[0]; m_gp = d[7:1]; end
    endtask

    // Memory access check, sampled 1 time unit after drive within the same cycle.
    task automatic mem_check(input string req, input logic [15:0] a,
                             input logic mq, input logic rf);
        @(negedge clk);
        cpu_addr = a; mreq_n = mq; rfsh_n = rf; iorq_n = 1'b1; wr_n = 1'b1;
        #1;
        check(req, {10'd0, phys_addr}, {10'd0, exp_phys(a)});
        check(req, {24'd0, chip_sel_n}, {24'd0, exp_cs(a, mq, rf)});
        mreq_n = 1'b1; rfsh_n = 1'b1;
    endtask

    task automatic check_all_windows(input string req);
        for (int w = 0; w < 4; w++) begin
            logic [15:0] a;
            a = {w[1:0], 14'($urandom)};
            mem_check(req, a, 1'b0, 1'b1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5A17));
        m_en = 1'b0; m_gp = '0;
        for (int i = 0; i < 4; i++) m_map[i] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        #1;
        check("R1 gp_out", {25'd0, gp_out}, 32'd0);
        // R2: disabled forces top page in every window; R8 offset
        check_all_windows("R2 boot page");
        mem_check("R8 offset", 16'h2ABC, 1'b0, 1'b1);

        // R4 load all entries, still disabled -> R2 holds regardless
        io_write(8'h60, 8'h00);
        io_write(8'h61, 8'h3C);
        io_write(8'h62, 8'hA5);
        io_write(8'h63, 8'h7F);
        check_all_windows("R2 entries loaded but disabled");

        // R6 enable + gp bits
        io_write(8'h64, 8'hAB);
        #1;
        check("R6 gp_out", {25'd0, gp_out}, 32'h55);
        check_all_windows("R3 enabled windows");
        mem_check("R3 window0 offset corner", 16'h3FFF, 1'b0, 1'b1);
        mem_check("R3 window3 offset corner", 16'hC000, 1'b0, 1'b1);

        // R4 new value visible next cycle
        io_write(8'h62, 8'hE1);
        mem_check("R4 rewrite window2", 16'h8123, 1'b0, 1'b1);

        // R5 ignored writes
        bus_cycle(16'h0061, 8'h11, 1'b1, 1'b0, 1'b1);  // iorq high
        bus_cycle(16'h0061, 8'h12, 1'b0, 1'b1, 1'b1);  // wr high
        bus_cycle(16'h0065, 8'h13, 1'b0, 1'b0, 1'b1);  // outside block
        bus_cycle(16'h005F, 8'h14, 1'b0, 1'b0, 1'b1);  // below block
        bus_cycle(16'h0060, 8'h15, 1'b1, 1'b0, 1'b0);  // memory write
        check_all_windows("R5 ignored writes");
        #1 check("R5 gp unchanged", {25'd0, gp_out}, 32'h55);

        // R7 refresh and I/O cycles deselect
        mem_check("R7 refresh", 16'h4000, 1'b0, 1'b0);
        mem_check("R7 no mreq", 16'h4000, 1'b1, 1'b1);
        for (int b = 0; b < 8; b++) begin
            io_write(8'h60, {b[2:0], 5'h0A});
            mem_check("R7 bank select", 16'h0123, 1'b0, 1'b1);
        end

        // R9 disable then re-enable
        io_write(8'h64, 8'h00);
        check_all_windows("R9 disabled again");
        io_write(8'h64, 8'h01);
        check_all_windows("R9 re-enabled restore");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) io_write(8'h60 + 8'($urandom_range(0, 3)), 8'($urandom));
            else if (k == 4) io_write(8'h64, 8'($urandom));
            else if (k == 5) io_write(8'($urandom_range(8'h58, 8'h6F)), 8'($urandom));
            else if (k == 6) bus_cycle(16'($urandom), 8'($urandom), 1'b1, 1'b0, 1'b0);
            else mem_check("R3 R7 R8 random", 16'($urandom), 1'($urandom), 1'($urandom));
        end
        #1 check("R6 random gp", {25'd0, gp_out}, {25'd0, m_gp});

        // R1 reset again mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        m_en = 1'b0; m_gp = '0;
        #1 check("R1 reset again gp", {25'd0, gp_out}, 32'd0);
        check_all_windows("R1 R2 reset disables map");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule